// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block produces the frequency-offset profile that steers a fractional-N PLL feedback divider, so that the synthesized clock sweeps below its nominal frequency. The profile is a symmetric triangle. It starts at zero, falls linearly to minus the selected depth, and climbs back to zero. One sweep takes a fixed number of reference-clock cycles. With the default 444 cycles and a reference near 14.318 MHz, the sweep rate is close to 32 kHz. The output is a signed fixed-point fraction of the nominal divide ratio. It is never positive, so the peak output frequency is the nominal one.

A two-bit select picks one of three spread depths or disables modulation. The select is sampled only when a sweep begins, so a depth change never causes a jump in the offset. The select lines share board pins with power-up straps. A strap-done input therefore keeps the generator in its off state until the strap latch point has passed. The sigma-delta modulator, the PLL and its loop filter sit downstream and are not part of this block.

Top module: `ssc_downspread_gen`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is asserted, `offset_o` is 0 and the generator is in the off state.
- R2: `offset_o` is never greater than zero.
- R3: Select encoding: 00 = off, 01 = 0.50 %, 10 = 1.00 %, 11 = 1.25 %. With FRAC_W = 24, the per-cycle step is 378, 756 or 945 LSBs, and the trough is minus 222 times the step: -83916, -167832 or -209790.
- R4: A sweep lasts 2*HALF_CYC = 444 cycles. In the cycle with phase k (0..443), `offset_o` equals -step*k for k <= 222 and -step*(444-k) otherwise.
- R5: While the latched select is off, `offset_o` is held at exactly 0 and the phase counter stays at 0. An off request that arrives mid-sweep takes effect at the next sweep start.
- R6: A select change during a sweep has no effect until the clock edge that starts the next sweep. From the off state, a new select is adopted at the next clock edge.
- R7: While `strap_done_i` is low, the select inputs are ignored and treated as off. After it rises, the select is adopted at the next sweep start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_done_i | input | 1 | High once the power-up strap latch point has passed |
| depth_sel_i | input | 2 | Spread depth select (00 off, 01 0.50 %, 10 1.00 %, 11 1.25 %) |
| offset_o | output | FRAC_W+1 | Signed divider offset, fraction of nominal scaled by 2^FRAC_W |

## Verification
Every cycle, the in-line assertions check the following: the offset sign, the bound on the magnitude set by the latched depth, a slope of exactly one step per cycle inside a sweep, the exact trough at mid-sweep, the frozen select within a sweep, and the quiet off state. The bench scenarios show what the assertions cannot express. These are the absolute offset values cycle by cycle against a formula for the triangle, a sweep length of exactly 444 cycles, the sweep at which a mid-sweep select change or off request first shows up, the deferred start after the strap-done rise, and the reset values.

// File: rtl/ssc_downspread_gen.sv
`timescale 1ns/1ps
module ssc_downspread_gen #(
  parameter int FRAC_W   = 24,
  parameter int HALF_CYC = 222,
  parameter int PPM_LO   = 5000,
  parameter int PPM_MID  = 10000,
  parameter int PPM_HI   = 12500
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strap_done_i,
  input  logic [1:0]               depth_sel_i,
  output logic signed [FRAC_W:0]   offset_o
);

  localparam int PERIOD = 2 * HALF_CYC;
  localparam int CW     = $clog2(PERIOD);
  localparam longint UNIT = longint'(1) << FRAC_W;
  localparam logic [FRAC_W:0] STEP_LO  = (FRAC_W+1)'(((UNIT * PPM_LO)  / 1000000 + HALF_CYC / 2) / HALF_CYC);
  localparam logic [FRAC_W:0] STEP_MID = (FRAC_W+1)'(((UNIT * PPM_MID) / 1000000 + HALF_CYC / 2) / HALF_CYC);
  localparam logic [FRAC_W:0] STEP_HI  = (FRAC_W+1)'(((UNIT * PPM_HI)  / 1000000 + HALF_CYC / 2) / HALF_CYC);

  logic [1:0]      sel_q;
  logic [CW-1:0]   cnt_q;
  logic [FRAC_W:0] mag_q;
  logic [FRAC_W:0] step;
  logic            sweep_start;
  logic            falling;

  always_comb begin
    case (sel_q)
      2'b01:   step = STEP_LO;
      2'b10:   step = STEP_MID;
      2'b11:   step = STEP_HI;
      default: step = '0;
    endcase
  end

  assign sweep_start = (sel_q == 2'b00) || (cnt_q == CW'(PERIOD - 1));
  assign falling     = cnt_q < CW'(HALF_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 2'b00;
      cnt_q <= '0;
      mag_q <= '0;
    end else if (sweep_start) begin
      sel_q <= strap_done_i ? depth_sel_i : 2'b00;
      cnt_q <= '0;
      mag_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      mag_q <= falling ? mag_q + step : mag_q - step;
    end
  end

  assign offset_o = -$signed(mag_q);

  p_never_positive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(offset_o) <= 0);

  p_within_depth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    longint'(mag_q) <= longint'(step) * HALF_CYC);

  p_trough_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != 2'b00 && cnt_q == CW'(HALF_CYC)) |-> longint'(mag_q) == longint'(step) * HALF_CYC);

  p_slope_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (mag_q == $past(mag_q) + step) || (mag_q + step == $past(mag_q)));

  p_phase_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD));

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 2'b00) |-> (offset_o == '0 && cnt_q == '0));

  p_sel_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(sel_q));

  p_strap_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strap_done_i && sel_q == 2'b00) |=> sel_q == 2'b00);

endmodule

// File: tb/test_ssc_downspread_gen.sv
`timescale 1ns/1ps
module test_ssc_downspread_gen;

  typedef struct {
    int    val;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strap = 1'b0;
  logic [1:0]        sel = 2'b00;
  logic signed [24:0] offset;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int m_sel = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  ssc_downspread_gen i_ssc_downspread_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .strap_done_i (strap),
    .depth_sel_i  (sel),
    .offset_o     (offset)
  );

  function automatic int step_of(int s);
    case (s)
      1: return 378;
      2: return 756;
      3: return 945;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_off(int s, int k);
    int tri_v;
    tri_v = (k <= 222) ? k : 444 - k;
    return -(step_of(s) * tri_v);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: offset actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int n, logic [1:0] s, logic r, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      sel   = s;
      strap = r;
      if (m_cnt == 443 || m_sel == 0) begin
        m_sel = r ? int'(s) : 0;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      it.val = expect_off(m_sel, m_cnt);
      it.tag = (m_sel != 0 && m_cnt == 222) ? "R3" : tag;
      q.push_back(it);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", int'(offset), 0);
    sel   = 2'b00;
    strap = 1'b0;
    m_sel = 0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    check("R1", int'(offset), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, int'(offset), it.val);
        checks++;
        if (offset > 0) begin
          errors++;
          $display("FAIL R2: offset actual %0d expected <= 0", offset);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(offset), 0);
    rst_n = 1'b1;
    drive(888, 2'b01, 1'b1, "R4");
    drive(100, 2'b10, 1'b1, "R6");
    drive(500, 2'b10, 1'b1, "R6");
    drive(900, 2'b11, 1'b1, "R4");
    drive(120, 2'b00, 1'b1, "R5");
    drive(500, 2'b00, 1'b1, "R5");
    drive(60, 2'b11, 1'b0, "R7");
    drive(460, 2'b11, 1'b1, "R7");
    drive(200, 2'b01, 1'b1, "R6");
    do_reset();
    drive(50, 2'b10, 1'b0, "R7");
    drive(450, 2'b10, 1'b1, "R4");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule